// File: doc/BRIEF.md
# Chained Readout Token Sequencer

One copy of this block sits in each chip of a chain whose chips empty their event memories one after another. A start token arriving from the upstream chip makes this chip read its stored frames from a local memory and send them out serially, one bit per clock, with a transmit-on flag that marks valid bits. When the last frame has gone out, the block hands a one-cycle end token to the downstream chip, which uses it as its own start.

The first frame slot of the memory holds no valid event. It is never sent, so a memory of `DEPTH` slots holds `DEPTH-1` usable events. Configuration bits let the chain work around a dead chip. A chip can take its start from a dedicated bypass input, skipping a dead neighbour upstream. It can send its end token on a dedicated bypass output, skipping a dead neighbour downstream. It can also take itself out of the chain. The data and transmit-on lines go to shared bus lines through output enables, and each enable can be forced off by configuration so that a stuck driver can be isolated.

Top module: `rdo_chain_seq`

## Requirements
- R1: While reset is low, and after it is released with no start seen, txOn, both end tokens, dataOut and both output enables are 0.
- R2: A start rising edge sends frames at addresses 1 through count-1 in ascending order, each `FRAME_W` bits MSB first, back to back with no gap. txOn is high for exactly those bit cycles. The frame at address 0 is never sent. The first bit appears in the second cycle after the clock edge that samples the start edge.
- R3: If the stored count is 0 or 1, no bit is sent and the end token is high for one cycle, in the cycle right after the edge that samples the start.
- R4: After a non-empty readout, the end token is high for exactly one cycle, in the cycle right after the last bit, and never while txOn is high.
- R5: With cfgPrevDead = 0, the start is taken from startTok and startBypassIn is ignored. With cfgPrevDead = 1, the start is taken from startBypassIn and startTok is ignored.
- R6: With cfgNextDead = 0, the end token appears on endTok and endBypassOut stays 0. With cfgNextDead = 1, the token appears on endBypassOut and endTok stays 0.
- R7: With cfgSelfBypass = 1, a start produces no readout and no end token.
- R8: dataOe is high exactly when txOn is high and cfgDataOff is 0. dataOut is 0 whenever txOn is low.
- R9: txOnOe is high exactly when txOn is high and cfgTxOff is 0.
- R10: chipSat is high when frameCnt >= `DEPTH` (128). A count above `DEPTH` is treated as `DEPTH`, so a full memory sends 127 frames.
- R11: Start edges that arrive while a readout is running are ignored. They do not restart the readout or add an end token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startTok | input | 1 | Start token from the upstream chip |
| startBypassIn | input | 1 | Start token from the chip two places upstream |
| cfgPrevDead | input | 1 | Take the start from startBypassIn |
| cfgNextDead | input | 1 | Send the end token on endBypassOut |
| cfgSelfBypass | input | 1 | Take this chip out of the chain |
| cfgDataOff | input | 1 | Force the data output enable off |
| cfgTxOff | input | 1 | Force the transmit-on output enable off |
| frameCnt | input | 8 | Number of frame slots written, including slot 0 |
| rdAddr | output | 7 | Memory read address |
| rdData | input | FRAME_W | Memory word at rdAddr, read in the same cycle |
| dataOut | output | 1 | Serial data bit |
| dataOe | output | 1 | Bus enable for dataOut |
| txOn | output | 1 | High while dataOut carries a valid bit |
| txOnOe | output | 1 | Bus enable for txOn |
| endTok | output | 1 | End token to the downstream chip |
| endBypassOut | output | 1 | End token to the chip two places downstream |
| chipSat | output | 1 | Memory full |

## Verification
Readouts are run with stored counts of 0, 1, 2, 5, 127 and one above the depth. These separate the empty path, a single frame, frame-to-frame handover, and the clamp at a full memory. Each memory word is a distinct function of its address, so a skipped, repeated or slot-0 frame shows up as a bit mismatch. Start tokens are sent on the selected line and on the ignored line, with each token-routing setting and with self-bypass. This separates correct token steering from a chip that reacts to both lines. A second start during a long readout shows whether the sequencer restarts. Runs with each output enable forced off check that the enable is gated while the txOn and data values stay unchanged.

// File: rtl/rdo_seq_pkg.sv
package rdo_seq_pkg;
  // Strobes from the sequencer control to the serializer datapath.
  typedef struct packed {
    logic load;    // capture rdData into the shifter
    logic shift;   // advance the shifter by one bit
    logic active;  // a frame bit is on the line this cycle
  } rdo_strobe_t;
endpackage

// File: rtl/rdo_seq_ctrl.sv
module rdo_seq_ctrl
  import rdo_seq_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int DEPTH   = 128,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = ADDR_W + 1,
  localparam int BIT_W  = (FRAME_W > 1) ? $clog2(FRAME_W) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startTok,
  input  logic              startBypassIn,
  input  logic              cfgPrevDead,
  input  logic              cfgNextDead,
  input  logic              cfgSelfBypass,
  input  logic [CNT_W-1:0]  frameCnt,
  output logic [ADDR_W-1:0] rdAddr,
  output rdo_strobe_t       strb,
  output logic              endTok,
  output logic              endBypassOut,
  output logic              chipSat
);
  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SHIFT} seqState_t;

  seqState_t        state;
  logic             startPrev;
  logic             endPulse;
  logic [CNT_W-1:0] addr;
  logic [CNT_W-1:0] cntLat;
  logic [BIT_W-1:0] bitCnt;

  logic             startSel;
  logic             startRise;
  logic [CNT_W-1:0] cntEff;
  logic             lastBit;
  logic             lastFrame;

  assign startSel  = cfgPrevDead ? startBypassIn : startTok;
  assign startRise = startSel & ~startPrev;
  assign cntEff    = (frameCnt > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : frameCnt;
  assign chipSat   = (frameCnt >= CNT_W'(DEPTH));
  assign lastBit   = (state == S_SHIFT) && (bitCnt == '0);
  assign lastFrame = (addr == cntLat);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      startPrev <= 1'b0;
      endPulse  <= 1'b0;
      addr      <= '0;
      cntLat    <= '0;
      bitCnt    <= '0;
    end else begin
      startPrev <= startSel;
      endPulse  <= 1'b0;
      case (state)
        S_IDLE: begin
          if (startRise && !cfgSelfBypass) begin
            cntLat <= cntEff;
            if (cntEff <= CNT_W'(1)) begin
              endPulse <= 1'b1;
            end else begin
              addr  <= CNT_W'(1);
              state <= S_LOAD;
            end
          end
        end
        S_LOAD: begin
          addr   <= addr + CNT_W'(1);
          bitCnt <= BIT_W'(FRAME_W - 1);
          state  <= S_SHIFT;
        end
        S_SHIFT: begin
          if (bitCnt == '0) begin
            if (lastFrame) begin
              state    <= S_IDLE;
              endPulse <= 1'b1;
            end else begin
              addr   <= addr + CNT_W'(1);
              bitCnt <= BIT_W'(FRAME_W - 1);
            end
          end else begin
            bitCnt <= bitCnt - BIT_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign rdAddr      = addr[ADDR_W-1:0];
  assign strb.load   = (state == S_LOAD) || (lastBit && !lastFrame);
  assign strb.shift  = (state == S_SHIFT) && !strb.load;
  assign strb.active = (state == S_SHIFT);

  assign endTok       = endPulse & ~cfgNextDead;
  assign endBypassOut = endPulse & cfgNextDead;

  // R4: end token lasts one cycle and never overlaps a sent bit
  assert_end_one_cycle_R4: assert property (@(posedge clk) disable iff (!rstN)
    endPulse |=> !endPulse);
  assert_no_tx_with_end_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(endPulse && strb.active));
  // R2: slot 0 is never fetched, nor anything past the latched count
  assert_load_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> (addr >= CNT_W'(1)) && (addr < cntLat));
  // R10: latched count never exceeds the depth
  assert_cnt_clamp_R10: assert property (@(posedge clk) disable iff (!rstN)
    cntLat <= CNT_W'(DEPTH));
  // R7: a self-bypassed idle chip stays idle
  assert_bypass_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgSelfBypass && state == S_IDLE) |=> state == S_IDLE);
endmodule

// File: rtl/rdo_seq_datapath.sv
module rdo_seq_datapath
  import rdo_seq_pkg::*;
#(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  rdo_strobe_t        strb,
  input  logic [FRAME_W-1:0] rdData,
  input  logic               cfgDataOff,
  input  logic               cfgTxOff,
  output logic               dataOut,
  output logic               dataOe,
  output logic               txOn,
  output logic               txOnOe
);
  logic [FRAME_W-1:0] shReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg <= '0;
    end else if (strb.load) begin
      shReg <= rdData;
    end else if (strb.shift) begin
      shReg <= shReg << 1;
    end
  end

  assign txOn    = strb.active;
  assign dataOut = strb.active & shReg[FRAME_W-1];
  assign dataOe  = strb.active & ~cfgDataOff;
  assign txOnOe  = strb.active & ~cfgTxOff;

  // R8: the shifter only moves while bits are on the line
  assert_shift_when_active_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.shift |-> strb.active);
endmodule

// File: rtl/rdo_chain_seq.sv
module rdo_chain_seq
  import rdo_seq_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int DEPTH   = 128,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = ADDR_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startTok,
  input  logic               startBypassIn,
  input  logic               cfgPrevDead,
  input  logic               cfgNextDead,
  input  logic               cfgSelfBypass,
  input  logic               cfgDataOff,
  input  logic               cfgTxOff,
  input  logic [CNT_W-1:0]   frameCnt,
  output logic [ADDR_W-1:0]  rdAddr,
  input  logic [FRAME_W-1:0] rdData,
  output logic               dataOut,
  output logic               dataOe,
  output logic               txOn,
  output logic               txOnOe,
  output logic               endTok,
  output logic               endBypassOut,
  output logic               chipSat
);
  rdo_strobe_t strb;

  rdo_seq_ctrl #(.FRAME_W(FRAME_W), .DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .startTok(startTok), .startBypassIn(startBypassIn),
    .cfgPrevDead(cfgPrevDead), .cfgNextDead(cfgNextDead),
    .cfgSelfBypass(cfgSelfBypass), .frameCnt(frameCnt), .rdAddr(rdAddr),
    .strb(strb), .endTok(endTok), .endBypassOut(endBypassOut), .chipSat(chipSat)
  );

  rdo_seq_datapath #(.FRAME_W(FRAME_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .rdData(rdData),
    .cfgDataOff(cfgDataOff), .cfgTxOff(cfgTxOff), .dataOut(dataOut),
    .dataOe(dataOe), .txOn(txOn), .txOnOe(txOnOe)
  );
endmodule

// File: tb/rdo_chain_seq_tb_top.sv
`timescale 1ns/1ps
module rdo_chain_seq_tb_top;
  localparam int W = 16;
  localparam int DEPTH = 128;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startTok = 0, startBypassIn = 0;
  logic cfgPrevDead = 0, cfgNextDead = 0, cfgSelfBypass = 0, cfgDataOff = 0, cfgTxOff = 0;
  logic [7:0] frameCnt = '0;
  logic [6:0] rdAddr;
  logic [W-1:0] rdData;
  logic dataOut, dataOe, txOn, txOnOe, endTok, endBypassOut, chipSat;

  int checks = 0, fails = 0;
  int cyc = 0;
  int txCnt = 0, firstTx = -1, endCyc = -1, endTokCnt = 0, endBypCnt = 0;
  bit expBits[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [W-1:0] memWord(input logic [6:0] a);
    return W'(a * 16'd40503) ^ 16'h5A5A;
  endfunction
  assign rdData = memWord(rdAddr);

  rdo_chain_seq #(.FRAME_W(W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .startTok(startTok), .startBypassIn(startBypassIn),
    .cfgPrevDead(cfgPrevDead), .cfgNextDead(cfgNextDead), .cfgSelfBypass(cfgSelfBypass),
    .cfgDataOff(cfgDataOff), .cfgTxOff(cfgTxOff), .frameCnt(frameCnt), .rdAddr(rdAddr),
    .rdData(rdData), .dataOut(dataOut), .dataOe(dataOe), .txOn(txOn), .txOnOe(txOnOe),
    .endTok(endTok), .endBypassOut(endBypassOut), .chipSat(chipSat)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every transmitted bit
  always @(negedge clk) begin
    if (rstN) begin
      if (txOn) begin
        txCnt++;
        if (firstTx < 0) firstTx = cyc;
        if (expBits.size() == 0) check(0, "R2 unexpected bit", 1, 0);
        else begin
          bit e;
          e = expBits.pop_front();
          if (dataOut !== e) check(0, "R2 data bit", int'(dataOut), int'(e));
        end
        if (dataOe !== !cfgDataOff) check(0, "R8 dataOe", int'(dataOe), int'(!cfgDataOff));
        if (txOnOe !== !cfgTxOff) check(0, "R9 txOnOe", int'(txOnOe), int'(!cfgTxOff));
      end else if (dataOut || dataOe || txOnOe) begin
        check(0, "R8 idle outputs", int'({dataOut, dataOe, txOnOe}), 0);
      end
      if (endTok) begin endTokCnt++; endCyc = cyc; end
      if (endBypassOut) begin endBypCnt++; endCyc = cyc; end
    end
  end

  // Driver: queues the expected bits and sends one start token
  task automatic doReadout(input int n, input bit viaByp, input bit nextDead,
                           input bit midStart, input string tag);
    int eff, e0, e1, sCyc, t;
    eff = (n > DEPTH) ? DEPTH : n;
    for (int f = 1; f < eff; f++)
      for (int b = W - 1; b >= 0; b--) expBits.push_back(memWord(7'(f))[b]);
    txCnt = 0; firstTx = -1; endCyc = -1;
    e0 = endTokCnt; e1 = endBypCnt;
    cfgPrevDead = viaByp; cfgNextDead = nextDead; frameCnt = 8'(n);
    @(negedge clk);
    if (viaByp) startBypassIn = 1; else startTok = 1;
    sCyc = cyc + 1;
    @(negedge clk);
    startTok = 0; startBypassIn = 0;
    if (midStart) begin
      repeat (10) @(negedge clk);
      if (viaByp) startBypassIn = 1; else startTok = 1;
      @(negedge clk);
      startTok = 0; startBypassIn = 0;
    end
    t = 0;
    while ((endTokCnt + endBypCnt) == (e0 + e1) && t < 5000) begin
      @(negedge clk); t++;
    end
    repeat (20) @(negedge clk);
    check(expBits.size() == 0, {tag, " R2 all bits sent"}, expBits.size(), 0);
    expBits.delete();
    check(txCnt == (eff - 1 > 0 ? eff - 1 : 0) * W, {tag, " R2 bit count"}, txCnt,
          (eff - 1 > 0 ? eff - 1 : 0) * W);
    if (eff > 1) begin
      check(firstTx == sCyc + 1, {tag, " R2 first bit cycle"}, firstTx, sCyc + 1);
      check(endCyc == sCyc + 1 + (eff - 1) * W, {tag, " R4 end cycle"}, endCyc,
            sCyc + 1 + (eff - 1) * W);
    end else begin
      check(endCyc == sCyc, {tag, " R3 empty end cycle"}, endCyc, sCyc);
    end
    check(endTokCnt - e0 == (nextDead ? 0 : 1), {tag, " R6 endTok count"}, endTokCnt - e0,
          nextDead ? 0 : 1);
    check(endBypCnt - e1 == (nextDead ? 1 : 0), {tag, " R6 endBypassOut count"},
          endBypCnt - e1, nextDead ? 1 : 0);
  endtask

  // Sends a start that must be ignored; nothing may come out
  task automatic idleStart(input bit onByp, input string tag);
    int e;
    e = endTokCnt + endBypCnt; txCnt = 0;
    frameCnt = 8'd5;
    @(negedge clk);
    if (onByp) startBypassIn = 1; else startTok = 1;
    @(negedge clk);
    startTok = 0; startBypassIn = 0;
    repeat (120) @(negedge clk);
    check(txCnt == 0, {tag, " no bits"}, txCnt, 0);
    check(endTokCnt + endBypCnt == e, {tag, " no end token"}, endTokCnt + endBypCnt, e);
  endtask

  initial begin
    #(200000 * 5);
    check(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check({txOn, endTok, endBypassOut, dataOut, dataOe, txOnOe} == 0, "R1 in reset",
          int'({txOn, endTok, endBypassOut, dataOut, dataOe, txOnOe}), 0);
    rstN = 1;
    repeat (3) @(negedge clk);
    check({txOn, endTok, endBypassOut, dataOut, dataOe, txOnOe} == 0, "R1 after reset",
          int'({txOn, endTok, endBypassOut, dataOut, dataOe, txOnOe}), 0);

    doReadout(0, 0, 0, 0, "cnt0");
    doReadout(1, 0, 0, 0, "cnt1");
    doReadout(2, 0, 0, 0, "cnt2");
    doReadout(5, 0, 0, 0, "cnt5");
    doReadout(5, 1, 0, 0, "R5 bypass start");
    doReadout(3, 0, 1, 0, "R6 bypass end");
    doReadout(1, 1, 1, 0, "R6 empty bypass end");
    doReadout(5, 0, 0, 1, "R11 mid start");

    cfgPrevDead = 0; idleStart(1, "R5 ignore bypass line");
    cfgPrevDead = 1; idleStart(0, "R5 ignore normal line");
    cfgPrevDead = 0; cfgSelfBypass = 1; idleStart(0, "R7 self bypass");
    cfgSelfBypass = 0;

    cfgDataOff = 1; doReadout(3, 0, 0, 0, "R8 data off");
    cfgDataOff = 0; cfgTxOff = 1; doReadout(3, 0, 0, 0, "R9 tx off");
    cfgTxOff = 0;

    frameCnt = 8'd127; @(negedge clk);
    check(chipSat == 0, "R10 sat at 127", int'(chipSat), 0);
    frameCnt = 8'd128; @(negedge clk);
    check(chipSat == 1, "R10 sat at 128", int'(chipSat), 1);
    doReadout(127, 0, 0, 0, "R10 cnt127");
    doReadout(200, 0, 0, 0, "R10 clamp");
    check(chipSat == 1, "R10 sat above depth", int'(chipSat), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule